// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps the time of day and the calendar date as packed BCD bytes. It counts seconds, minutes, hours, day of week, day of month, month and a two-digit year. A clock-enable input at the crystal rate, nominally 32.768 kHz, is divided down to a one-second tick that advances the chain. Hours run in either a 24-hour or a 12-hour format with a PM flag. Month lengths follow the calendar, and February gains a 29th day in leap years.

A bus interface sits next to this block. It loads any register through a byte-wide write port addressed 0 to 6, and it reads the live registers from the parallel outputs. A halt bit held in the seconds register stops the count. Any write to seconds restarts the sub-second divider, so the next tick arrives one full second after that write.

Top module: `bcd_rtc_counter`

## Requirements
- R1: While reset is held, the outputs read seconds 00 (halt bit 0), minutes 00, hours 0x00 (24-hour mode), weekday 1, date 01, month 01 and year 00.
- R2: Seconds and minutes count in packed BCD from 00 to 59. The low digit carries into the tens digit after 9. A second that steps 59 to 00 advances the minutes, and a minute that steps 59 to 00 advances the hours.
- R3: With hours bit 6 at 0 (24-hour mode), hours bits 5:0 count 00 to 23 in BCD. The step from 23 to 00 advances the date.
- R4: With hours bit 6 at 1 (12-hour mode), bits 4:0 hold 01 to 12 in BCD and bit 5 is PM. The hour steps 11 to 12 and toggles PM at that step, then steps 12 to 01 without a toggle. The step from 11 PM to 12 AM advances the date, so 0x71 becomes 0x52.
- R5: The date wraps to 01 and advances the month after day 30 for months 04, 06, 09 and 11, after day 31 for the other months, and after day 28 or 29 for February.
- R6: February has 29 days when the BCD year is divisible by 4, with year 00 counted as a leap year. Otherwise it has 28.
- R7: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R8: The weekday counts 1 to 7 and wraps from 7 to 1. It advances in the same step as the date rollover at midnight.
- R9: While seconds bit 7 (halt) is 1, no tick occurs and no register changes on its own. Clearing the bit resumes counting.
- R10: `tick_o` is a one-cycle pulse raised on the `DIV_COUNT`-th `osc_en` cycle of the divider, and it is suppressed when `osc_en` is low. A write to address 0 resets the divider, so the next tick is the `DIV_COUNT`-th `osc_en` cycle after that write.
- R11: When a write and a tick fall in the same cycle, the addressed register takes the written value. The other registers advance as the tick dictates, with carries taken from the values they held before the edge.
- R12: A write to address 7 has no effect. Unused high bits are stored as 0: minutes bit 7, hours bit 7, weekday bits 7:3, date bits 7:6 and month bits 7:5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_en | input | 1 | Clock enable at the crystal rate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 sec, 1 min, 2 hour, 3 weekday, 4 date, 5 month, 6 year |
| wr_data | input | 8 | Write data |
| sec_o | output | 8 | Halt bit 7, BCD seconds in bits 6:0 |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | Bit 6 mode, bit 5 PM or tens, BCD hour |
| wday_o | output | 8 | Weekday 1-7 |
| mday_o | output | 8 | BCD date |
| mon_o | output | 8 | BCD month |
| year_o | output | 8 | BCD year |
| tick_o | output | 1 | One-second pulse |

## Verification
The same cycle can carry both a register write from the bus side and the one-second tick, and those two events contend for the same registers. The bench restarts the divider with a seconds write, counts `DIV_COUNT` cycles, and lands a minutes or hours write exactly on the tick edge while seconds sits at 59. The check expects the written register to hold the written value, seconds to read 00, and any register above the written one to be left alone. A seconds write cannot coincide with a tick by construction, because that write restarts the divider.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;

  typedef enum logic [2:0] {
    REG_SEC  = 3'd0,
    REG_MIN  = 3'd1,
    REG_HOUR = 3'd2,
    REG_WDAY = 3'd3,
    REG_MDAY = 3'd4,
    REG_MON  = 3'd5,
    REG_YEAR = 3'd6,
    REG_NONE = 3'd7
  } reg_sel_e;

  // Next value of a two-digit packed BCD number (no upper wrap)
  function automatic logic [7:0] bcd_next(input logic [7:0] v);
    if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
    else                return {v[7:4], v[3:0] + 4'h1};
  endfunction

  // Divisible by 4: even tens need ones 0/4/8, odd tens need ones 2/6
  function automatic logic leap_year(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
    else      return (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // True when the next hour step is midnight
  function automatic logic hour_is_last(input logic [7:0] h);
    if (h[6]) return h[5] && (h[4:0] == 5'h11);
    else      return h[5:0] == 6'h23;
  endfunction

  function automatic logic [7:0] hour_advance(input logic [7:0] h);
    logic [7:0] n;
    if (h[6]) begin
      n = bcd_next({3'b000, h[4:0]});
      if (h[4:0] == 5'h11)      return {2'b01, ~h[5], 5'h12};
      else if (h[4:0] == 5'h12) return {2'b01, h[5], 5'h01};
      else                      return {2'b01, h[5], 5'h00} | (n & 8'h1F);
    end else begin
      n = bcd_next({2'b00, h[5:0]});
      if (h[5:0] == 6'h23) return 8'h00;
      else                 return n & 8'h3F;
    end
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_COUNT = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int CW = (DIV_COUNT > 2) ? $clog2(DIV_COUNT) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_COUNT - 1);

  logic [CW-1:0] cnt;

  assign tick = osc_en && run && !restart && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (restart)        cnt <= '0;
    else if (osc_en && run)  cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_bcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  reg_sel_e   sel,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic       run,
  output logic       day_carry
);
  logic [7:0] sec_r, min_r, hour_r;
  logic       sec_wrap, min_wrap;

  assign sec_wrap  = tick && (sec_r[6:0] == 7'h59);
  assign min_wrap  = sec_wrap && (min_r == 8'h59);
  assign day_carry = min_wrap && hour_is_last(hour_r);
  assign run       = !sec_r[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_r  <= 8'h00;
      min_r  <= 8'h00;
      hour_r <= 8'h00;
    end else begin
      if (sel == REG_SEC)       sec_r <= wr_data;
      else if (sec_wrap)        sec_r <= {sec_r[7], 7'h00};
      else if (tick)            sec_r <= {sec_r[7], 7'h00} | (bcd_next(sec_r & 8'h7F) & 8'h7F);

      if (sel == REG_MIN)       min_r <= wr_data & 8'h7F;
      else if (min_wrap)        min_r <= 8'h00;
      else if (sec_wrap)        min_r <= bcd_next(min_r);

      if (sel == REG_HOUR)      hour_r <= wr_data & 8'h7F;
      else if (min_wrap)        hour_r <= hour_advance(hour_r);
    end
  end

  assign sec_o  = sec_r;
  assign min_o  = min_r;
  assign hour_o = hour_r;
endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
  import rtc_bcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       day_carry,
  input  reg_sel_e   sel,
  input  logic [7:0] wr_data,
  output logic [7:0] wday_o,
  output logic [7:0] mday_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o,
  output logic       month_end,
  output logic       year_end
);
  logic [7:0] wday_r, mday_r, mon_r, year_r;

  assign month_end = day_carry && (mday_r == month_last(mon_r, year_r));
  assign year_end  = month_end && (mon_r == 8'h12);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wday_r <= 8'h01;
      mday_r <= 8'h01;
      mon_r  <= 8'h01;
      year_r <= 8'h00;
    end else begin
      if (sel == REG_WDAY)   wday_r <= wr_data & 8'h07;
      else if (day_carry)    wday_r <= (wday_r == 8'h07) ? 8'h01 : wday_r + 8'h01;

      if (sel == REG_MDAY)   mday_r <= wr_data & 8'h3F;
      else if (month_end)    mday_r <= 8'h01;
      else if (day_carry)    mday_r <= bcd_next(mday_r);

      if (sel == REG_MON)    mon_r <= wr_data & 8'h1F;
      else if (year_end)     mon_r <= 8'h01;
      else if (month_end)    mon_r <= bcd_next(mon_r);

      if (sel == REG_YEAR)   year_r <= wr_data;
      else if (year_end)     year_r <= (year_r == 8'h99) ? 8'h00 : bcd_next(year_r);
    end
  end

  assign wday_o = wday_r;
  assign mday_o = mday_r;
  assign mon_o  = mon_r;
  assign year_o = year_r;
endmodule

// File: rtl/bcd_rtc_counter.sv
module bcd_rtc_counter
  import rtc_bcd_pkg::*;
#(
  parameter int DIV_COUNT = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_en,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] wday_o,
  output logic [7:0] mday_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o,
  output logic       tick_o
);
  reg_sel_e sel;
  logic     tick, run, restart;
  logic     day_carry, month_end, year_end;

  assign sel     = wr_en ? reg_sel_e'(wr_addr) : REG_NONE;
  assign restart = (sel == REG_SEC);
  assign tick_o  = tick;

  rtc_prescaler #(.DIV_COUNT(DIV_COUNT)) u_div (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .run(run),
    .restart(restart), .tick(tick)
  );

  rtc_time_chain u_time (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sel(sel), .wr_data(wr_data),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .run(run),
    .day_carry(day_carry)
  );

  rtc_date_chain u_date (
    .clk(clk), .rst_n(rst_n), .day_carry(day_carry), .sel(sel),
    .wr_data(wr_data), .wday_o(wday_o), .mday_o(mday_o), .mon_o(mon_o),
    .year_o(year_o), .month_end(month_end), .year_end(year_end)
  );
endmodule

// File: rtl/rtc_counter_chk.sv
module rtc_counter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] wday_o,
  input logic [7:0] mday_o,
  input logic [7:0] mon_o,
  input logic [7:0] year_o,
  input logic       tick_o,
  input logic       day_carry,
  input logic       month_end,
  input logic       year_end
);
  AST_HALT_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    sec_o[7] |-> !tick_o); // R9

  AST_SECWR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd0) |=> !tick_o); // R10

  AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o); // R10

  AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_o && !wr_en) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o)
      && $stable(wday_o) && $stable(mday_o) && $stable(mon_o) && $stable(year_o))); // R2

  AST_H24_MIDNIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && !hour_o[6] && !(wr_en && wr_addr == 3'd2)) |=> hour_o == 8'h00); // R3

  AST_H12_MIDNIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && hour_o[6] && !(wr_en && wr_addr == 3'd2)) |=> hour_o == 8'h52); // R4

  AST_DATE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (month_end && !(wr_en && wr_addr == 3'd4)) |=> mday_o == 8'h01); // R5

  AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (year_end && year_o == 8'h99 && !(wr_en && wr_addr == 3'd6)) |=> year_o == 8'h00); // R7

  AST_WDAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && wday_o == 8'h07 && !(wr_en && wr_addr == 3'd3)) |=> wday_o == 8'h01); // R8
endmodule

bind bcd_rtc_counter rtc_counter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
  .mday_o(mday_o), .mon_o(mon_o), .year_o(year_o), .tick_o(tick_o),
  .day_carry(day_carry), .month_end(month_end), .year_end(year_end)
);

// File: tb/bcd_rtc_counter_test.sv
`timescale 1ns/1ps
module bcd_rtc_counter_test;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_en = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o;
  logic tick_o;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  bcd_rtc_counter #(.DIV_COUNT(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o),
    .hour_o(hour_o), .wday_o(wday_o), .mday_o(mday_o), .mon_o(mon_o),
    .year_o(year_o), .tick_o(tick_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Halt, load every register, then release with the seconds write last
  task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                          input logic [7:0] wd, input logic [7:0] md, input logic [7:0] mo,
                          input logic [7:0] y);
    wr(3'd0, 8'h80);
    wr(3'd1, m); wr(3'd2, h); wr(3'd3, wd);
    wr(3'd4, md); wr(3'd5, mo); wr(3'd6, y);
    wr(3'd0, s);
  endtask

  task automatic run_secs(input int k);
    repeat (DIV * k) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 sec", sec_o, 8'h00);   chk("R1 min", min_o, 8'h00);
    chk("R1 hour", hour_o, 8'h00); chk("R1 wday", wday_o, 8'h01);
    chk("R1 mday", mday_o, 8'h01); chk("R1 mon", mon_o, 8'h01);
    chk("R1 year", year_o, 8'h00);
  endtask

  task automatic t_24h_newyear;
    set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h24);
    run_secs(1);
    chk("R2 sec 58->59", sec_o, 8'h59);
    chk("R2 hour held", hour_o, 8'h23);
    run_secs(1);
    chk("R2 sec wrap", sec_o, 8'h00);
    chk("R2 min wrap", min_o, 8'h00);
    chk("R3 hour 23->00", hour_o, 8'h00);
    chk("R8 wday 7->1", wday_o, 8'h01);
    chk("R7 mon 12->01", mon_o, 8'h01);
    chk("R5 mday 31->01", mday_o, 8'h01);
    chk("R7 year 24->25", year_o, 8'h25);
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h31, 8'h12, 8'h99);
    run_secs(1);
    chk("R7 year 99->00", year_o, 8'h00);
    chk("R8 wday 3->4", wday_o, 8'h04);
    set_time(8'h09, 8'h19, 8'h09, 8'h01, 8'h05, 8'h05, 8'h05);
    run_secs(1);
    chk("R2 sec digit carry", sec_o, 8'h10);
  endtask

  task automatic t_12h;
    set_time(8'h59, 8'h59, 8'h71, 8'h02, 8'h15, 8'h06, 8'h30);
    run_secs(1);
    chk("R4 11PM->12AM", hour_o, 8'h52);
    chk("R4 date advances", mday_o, 8'h16);
    chk("R8 wday advances", wday_o, 8'h03);
    set_time(8'h59, 8'h59, 8'h51, 8'h03, 8'h16, 8'h06, 8'h30);
    run_secs(1);
    chk("R4 11AM->12PM", hour_o, 8'h72);
    chk("R4 noon keeps date", mday_o, 8'h16);
    set_time(8'h59, 8'h59, 8'h72, 8'h03, 8'h16, 8'h06, 8'h30);
    run_secs(1);
    chk("R4 12PM->1PM", hour_o, 8'h61);
    set_time(8'h59, 8'h59, 8'h49, 8'h03, 8'h16, 8'h06, 8'h30);
    run_secs(1);
    chk("R4 9AM->10AM", hour_o, 8'h50);
  endtask

  task automatic end_of_day(input string tag, input logic [7:0] md, input logic [7:0] mo,
                            input logic [7:0] y, input logic [7:0] exp_md,
                            input logic [7:0] exp_mo);
    set_time(8'h59, 8'h59, 8'h23, 8'h01, md, mo, y);
    run_secs(1);
    chk({tag, " mday"}, mday_o, exp_md);
    chk({tag, " mon"}, mon_o, exp_mo);
  endtask

  task automatic t_months;
    end_of_day("R5 Apr30", 8'h30, 8'h04, 8'h21, 8'h01, 8'h05);
    end_of_day("R5 Sep30", 8'h30, 8'h09, 8'h21, 8'h01, 8'h10);
    end_of_day("R5 Aug30", 8'h30, 8'h08, 8'h21, 8'h31, 8'h08);
    end_of_day("R5 Aug31", 8'h31, 8'h08, 8'h21, 8'h01, 8'h09);
    end_of_day("R5 Nov30", 8'h30, 8'h11, 8'h21, 8'h01, 8'h12);
  endtask

  task automatic t_leap;
    end_of_day("R6 Feb28 y24", 8'h28, 8'h02, 8'h24, 8'h29, 8'h02);
    end_of_day("R6 Feb29 y24", 8'h29, 8'h02, 8'h24, 8'h01, 8'h03);
    end_of_day("R6 Feb28 y23", 8'h28, 8'h02, 8'h23, 8'h01, 8'h03);
    end_of_day("R6 Feb28 y00", 8'h28, 8'h02, 8'h00, 8'h29, 8'h02);
    end_of_day("R6 Feb28 y12", 8'h28, 8'h02, 8'h12, 8'h29, 8'h02);
    end_of_day("R6 Feb28 y10", 8'h28, 8'h02, 8'h10, 8'h01, 8'h03);
  endtask

  task automatic t_halt;
    set_time(8'h05, 8'h10, 8'h10, 8'h01, 8'h01, 8'h01, 8'h01);
    wr(3'd0, 8'h85);
    run_secs(3);
    chk("R9 halted sec", sec_o, 8'h85);
    chk("R9 halted tick", {7'd0, tick_o}, 8'h00);
    wr(3'd0, 8'h05);
    run_secs(1);
    chk("R9 resumed", sec_o, 8'h06);
  endtask

  task automatic t_restart;
    set_time(8'h20, 8'h10, 8'h10, 8'h01, 8'h01, 8'h01, 8'h01);
    repeat (2) @(posedge clk);
    wr(3'd0, 8'h30);
    repeat (DIV - 1) @(posedge clk);
    @(negedge clk);
    chk("R10 no early tick", sec_o, 8'h30);
    chk("R10 tick raised", {7'd0, tick_o}, 8'h01);
    @(negedge clk);
    chk("R10 one second later", sec_o, 8'h31);
    chk("R10 tick is pulse", {7'd0, tick_o}, 8'h00);
    osc_en = 1'b0;
    repeat (5 * DIV) @(negedge clk);
    chk("R10 gated sec", sec_o, 8'h31);
    osc_en = 1'b1;
  endtask

  task automatic t_collision;
    set_time(8'h59, 8'h10, 8'h10, 8'h01, 8'h01, 8'h01, 8'h01);
    repeat (DIV - 1) @(posedge clk);
    wr(3'd1, 8'h30);
    chk("R11 sec advanced", sec_o, 8'h00);
    chk("R11 min written", min_o, 8'h30);
    chk("R11 hour kept", hour_o, 8'h10);
    set_time(8'h59, 8'h59, 8'h10, 8'h01, 8'h01, 8'h01, 8'h01);
    repeat (DIV - 1) @(posedge clk);
    wr(3'd2, 8'h05);
    chk("R11 hour written", hour_o, 8'h05);
    chk("R11 min wrapped", min_o, 8'h00);
    chk("R11 sec wrapped", sec_o, 8'h00);
  endtask

  task automatic t_ignore;
    set_time(8'h56, 8'h34, 8'h12, 8'h05, 8'h17, 8'h08, 8'h42);
    wr(3'd0, 8'hD6);
    wr(3'd7, 8'hFF);
    chk("R12 addr7 sec", sec_o, 8'hD6);   chk("R12 addr7 min", min_o, 8'h34);
    chk("R12 addr7 hour", hour_o, 8'h12); chk("R12 addr7 wday", wday_o, 8'h05);
    chk("R12 addr7 mday", mday_o, 8'h17); chk("R12 addr7 mon", mon_o, 8'h08);
    chk("R12 addr7 year", year_o, 8'h42);
    wr(3'd1, 8'hA5); chk("R12 min mask", min_o, 8'h25);
    wr(3'd4, 8'hC7); chk("R12 mday mask", mday_o, 8'h07);
    wr(3'd3, 8'hFE); chk("R12 wday mask", wday_o, 8'h06);
    wr(3'd5, 8'hF1); chk("R12 mon mask", mon_o, 8'h11);
    wr(3'd2, 8'hA3); chk("R12 hour mask", hour_o, 8'h23);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_24h_newyear();
    t_12h();
    t_months();
    t_leap();
    t_halt();
    t_restart();
    t_collision();
    t_ignore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule